// File: doc/BRIEF.md
# Instruction Decode and Execute Unit

This block is the combinational execute path for a compact 32-bit load/store instruction set. It takes one instruction word together with the two source register values already read from the register file. It splits the word into its fields and decodes the operation. It then picks the second ALU operand and produces a 32-bit result, the destination register index and a small set of control flags. The register file, the data memory and the pipeline registers around it belong to the enclosing core.

All register-to-register operations share one major opcode, and a low function field inside the word selects the operation. Each immediate arithmetic or logic operation has its own major opcode, and the ALU offers NAND and NOR as native operations. Loads and stores use the ALU output as the effective address. Branches use the ALU output as the difference of the two sources and also report whether the branch condition is met.

The unit has no clock and no state. There is no state register and there are no transitions. Every output follows the inputs within the same cycle.

Top module: `isa_exec_unit`

## Requirements
- R1: Bit fields are major code [31:26], first source index [25:21], second source index [20:16], result index [15:11], shift amount [10:6], function [5:0] and immediate [15:0]. A register-format operation reports the result index as `dest_reg`. Immediate-ALU operations and loads report the second source index. Any operation that does not write a register reports 0.
- R2: With major code 1, these function codes write `alu_out` and assert `reg_write`: 2 add, 3 subtract, 4 AND, 5 OR, 6 NAND (~(a&b)) and 7 NOR (~(a|b)). In each case the first operand is `rs_val` and the second is `rt_val`.
- R3: With major code 1, function 0 gives `rt_val` shifted left logically by the shift amount, and function 1 gives it shifted right logically. `rs_val` has no effect on either.
- R4: Major codes 2 to 7 perform add, subtract, AND, OR, NAND and NOR, in that order, on `rs_val` and the sign-extended 16-bit immediate. For example, 0xFFFB acts as -5.
- R5: Set-less-than compares signed two's-complement values and yields exactly 1 or 0. The register form is function 8 with major code 1, comparing `rs_val` with `rt_val`. The immediate form is major code 8, comparing `rs_val` with the immediate.
- R6: Add and subtract wrap modulo 2^32 and give no overflow indication.
- R7: Major code 9 (load) asserts `mem_read` and `reg_write` and gives `alu_out` = `rs_val` + sign-extended immediate.
- R8: Major code 10 (store) asserts `mem_write` only, with `reg_write` low. It gives the same address as a load.
- R9: Major code 11 asserts `branch_eq` and major code 12 asserts `branch_ne`. Both give `alu_out` = `rs_val` - `rt_val`. `branch_taken` is high when the sources are equal (code 11) or when they differ (code 12).
- R10: Major code 0, major codes 13 to 63, and function codes 9 to 63 under major code 1 are no-ops. All flags stay low, and `alu_out` and `dest_reg` are 0.
- R11: Register 0 is an ordinary destination. An add-immediate with second source index 0 reports `dest_reg` 0 with `reg_write` high and carries the computed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| alu_out | output | 32 | ALU result, memory address or branch difference |
| dest_reg | output | 5 | Register index to write |
| reg_write | output | 1 | Result is written to `dest_reg` |
| mem_read | output | 1 | Load from the address on `alu_out` |
| mem_write | output | 1 | Store to the address on `alu_out` |
| branch_eq | output | 1 | Branch-if-equal instruction |
| branch_ne | output | 1 | Branch-if-not-equal instruction |
| branch_taken | output | 1 | Branch condition is met |

## Verification
The bench sweeps all 64 major codes. Under the register-format code it also sweeps all 64 function codes, so every defined operation is seen and every undefined code is confirmed quiet. Each code is tried with operand pairs drawn from zero, one, all-ones, both signed extremes and mixed patterns. These pairs separate signed from unsigned comparison, expose wrap-around at the extremes and distinguish NAND/NOR from AND/OR. Immediates 0x7FFF, 0x8000 and 0xFFFB show whether sign extension is applied. Shift amounts 0, 1, 5 and 31 show which operand is shifted. Varying the source index fields, including index 0, separates the result index from the second source index.

// File: rtl/isa_exec_pkg.sv
package isa_exec_pkg;

    localparam int INSTR_W   = 32;
    localparam int OPC_W     = 6;
    localparam int REG_IDX_W = 5;
    localparam int SHAMT_W   = 5;
    localparam int FUNCT_W   = 6;
    localparam int IMM_W     = 16;

    localparam logic [OPC_W-1:0] OPC_NOP   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_REG   = 6'd1;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_SUBI  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_NANDI = 6'd6;
    localparam logic [OPC_W-1:0] OPC_NORI  = 6'd7;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd9;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd10;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd11;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'd12;

    typedef enum logic [3:0] {
        ALU_SLL  = 4'd0,
        ALU_SRL  = 4'd1,
        ALU_ADD  = 4'd2,
        ALU_SUB  = 4'd3,
        ALU_AND  = 4'd4,
        ALU_OR   = 4'd5,
        ALU_NAND = 4'd6,
        ALU_NOR  = 4'd7,
        ALU_SLT  = 4'd8,
        ALU_ZERO = 4'd9
    } alu_op_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    use_imm;
        logic    dest_is_rd;
        logic    reg_write;
        logic    mem_read;
        logic    mem_write;
        logic    br_eq;
        logic    br_ne;
    } ctrl_t;

    // Function codes 0..8 and immediate codes 2..8 share one numbering.
    function automatic alu_op_e code_to_alu(input logic [5:0] code);
        alu_op_e op;
        unique case (code)
            6'd0:    op = ALU_SLL;
            6'd1:    op = ALU_SRL;
            6'd2:    op = ALU_ADD;
            6'd3:    op = ALU_SUB;
            6'd4:    op = ALU_AND;
            6'd5:    op = ALU_OR;
            6'd6:    op = ALU_NAND;
            6'd7:    op = ALU_NOR;
            6'd8:    op = ALU_SLT;
            default: op = ALU_ZERO;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/isa_field_split.sv
module isa_field_split
    import isa_exec_pkg::*;
(
    input  logic [INSTR_W-1:0]   instr,
    output logic [OPC_W-1:0]     opcode,
    output logic [REG_IDX_W-1:0] rt_idx,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [SHAMT_W-1:0]   shamt,
    output logic [FUNCT_W-1:0]   funct,
    output logic [IMM_W-1:0]     imm
);
    localparam int OPC_LO = INSTR_W - OPC_W;
    localparam int RT_LO  = OPC_LO - 2*REG_IDX_W;
    localparam int RD_LO  = RT_LO - REG_IDX_W;
    localparam int SH_LO  = RD_LO - SHAMT_W;

    always_comb begin
        opcode = instr[INSTR_W-1:OPC_LO];
        rt_idx = instr[RT_LO +: REG_IDX_W];
        rd_idx = instr[RD_LO +: REG_IDX_W];
        shamt  = instr[SH_LO +: SHAMT_W];
        funct  = instr[FUNCT_W-1:0];
        imm    = instr[IMM_W-1:0];
    end
endmodule

// File: rtl/isa_ctrl_decode.sv
module isa_ctrl_decode
    import isa_exec_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    output ctrl_t              ctrl
);
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ZERO;
        unique case (opcode)
            OPC_REG: begin
                if (funct <= 6'd8) begin
                    ctrl.alu_op     = code_to_alu(funct);
                    ctrl.dest_is_rd = 1'b1;
                    ctrl.reg_write  = 1'b1;
                end
            end
            OPC_ADDI, OPC_SUBI, OPC_ANDI, OPC_ORI,
            OPC_NANDI, OPC_NORI, OPC_SLTI: begin
                ctrl.alu_op    = code_to_alu(opcode);
                ctrl.use_imm   = 1'b1;
                ctrl.reg_write = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.alu_op    = ALU_ADD;
                ctrl.use_imm   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.mem_read  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_op    = ALU_ADD;
                ctrl.use_imm   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.br_eq  = 1'b1;
            end
            OPC_BNE: begin
                ctrl.alu_op = ALU_SUB;
                ctrl.br_ne  = 1'b1;
            end
            default: begin
                ctrl.alu_op = ALU_ZERO;
            end
        endcase
    end

    always_comb begin
        assert_single_kind_R9: assert ($onehot0({ctrl.mem_read, ctrl.mem_write, ctrl.br_eq, ctrl.br_ne}))
            else $error("decoder raised more than one access kind");
        if (ctrl.mem_write || ctrl.br_eq || ctrl.br_ne) begin
            assert_no_write_R8: assert (!ctrl.reg_write)
                else $error("store or branch requests a register write");
        end
    end
endmodule

// File: rtl/isa_operand_sel.sv
module isa_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic [DATA_W-1:0] rt_val,
    input  logic              use_imm,
    output logic [DATA_W-1:0] op_b
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        op_b    = use_imm ? imm_ext : rt_val;
    end
endmodule

// File: rtl/isa_alu.sv
module isa_alu
    import isa_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [SH_W-1:0]   sh,
    output logic [DATA_W-1:0] result
);
    logic less;

    always_comb begin
        less = $signed(a) < $signed(b);
        unique case (op)
            ALU_SLL:  result = b << sh;
            ALU_SRL:  result = b >> sh;
            ALU_ADD:  result = a + b;
            ALU_SUB:  result = a - b;
            ALU_AND:  result = a & b;
            ALU_OR:   result = a | b;
            ALU_NAND: result = ~(a & b);
            ALU_NOR:  result = ~(a | b);
            ALU_SLT:  result = {{(DATA_W-1){1'b0}}, less};
            default:  result = '0;
        endcase
    end

    always_comb begin
        if (op == ALU_SLT) begin
            assert_slt_bool_R5: assert (result[DATA_W-1:1] == '0)
                else $error("set-less-than result wider than one bit");
        end
    end
endmodule

// File: rtl/isa_exec_unit.sv
module isa_exec_unit
    import isa_exec_pkg::*;
(
    input  logic [31:0] instr,
    input  logic [31:0] rs_val,
    input  logic [31:0] rt_val,
    output logic [31:0] alu_out,
    output logic [4:0]  dest_reg,
    output logic        reg_write,
    output logic        mem_read,
    output logic        mem_write,
    output logic        branch_eq,
    output logic        branch_ne,
    output logic        branch_taken
);
    localparam int DATA_W = INSTR_W;

    logic [OPC_W-1:0]     opcode;
    logic [REG_IDX_W-1:0] rt_idx;
    logic [REG_IDX_W-1:0] rd_idx;
    logic [SHAMT_W-1:0]   shamt;
    logic [FUNCT_W-1:0]   funct;
    logic [IMM_W-1:0]     imm;
    ctrl_t                ctrl;
    logic [DATA_W-1:0]    op_b;

    isa_field_split i_split (
        .instr  (instr),
        .opcode (opcode),
        .rt_idx (rt_idx),
        .rd_idx (rd_idx),
        .shamt  (shamt),
        .funct  (funct),
        .imm    (imm)
    );

    isa_ctrl_decode i_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctrl   (ctrl)
    );

    isa_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) i_opsel (
        .imm     (imm),
        .rt_val  (rt_val),
        .use_imm (ctrl.use_imm),
        .op_b    (op_b)
    );

    isa_alu #(.DATA_W(DATA_W)) i_alu (
        .op     (ctrl.alu_op),
        .a      (rs_val),
        .b      (op_b),
        .sh     (shamt),
        .result (alu_out)
    );

    always_comb begin
        reg_write    = ctrl.reg_write;
        mem_read     = ctrl.mem_read;
        mem_write    = ctrl.mem_write;
        branch_eq    = ctrl.br_eq;
        branch_ne    = ctrl.br_ne;
        branch_taken = (ctrl.br_eq && (rs_val == rt_val)) ||
                       (ctrl.br_ne && (rs_val != rt_val));
        if (!ctrl.reg_write)
            dest_reg = '0;
        else if (ctrl.dest_is_rd)
            dest_reg = rd_idx;
        else
            dest_reg = rt_idx;
    end

    always_comb begin
        if (!(reg_write || mem_read || mem_write || branch_eq || branch_ne)) begin
            assert_quiet_zero_R10: assert (alu_out == '0 && dest_reg == '0 && !branch_taken)
                else $error("no-op drives a nonzero output");
        end
        if (mem_read) begin
            assert_load_writes_R7: assert (reg_write && !mem_write)
                else $error("load without register write");
        end
        if (branch_taken) begin
            assert_taken_is_branch_R9: assert (branch_eq || branch_ne)
                else $error("taken without branch");
        end
    end
endmodule

// File: tb/test_isa_exec_unit.sv
`timescale 1ns/1ps
module test_isa_exec_unit;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [31:0] instr, rs_val, rt_val, alu_out;
    logic [4:0]  dest_reg;
    logic reg_write, mem_read, mem_write, branch_eq, branch_ne, branch_taken;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    isa_exec_unit i_isa_exec_unit (
        .instr(instr), .rs_val(rs_val), .rt_val(rt_val), .alu_out(alu_out),
        .dest_reg(dest_reg), .reg_write(reg_write), .mem_read(mem_read),
        .mem_write(mem_write), .branch_eq(branch_eq), .branch_ne(branch_ne),
        .branch_taken(branch_taken)
    );

    logic [31:0] vals [0:7];
    logic [15:0] imms [0:4];
    logic [4:0]  shs  [0:3];

    function automatic logic [31:0] ref_op(input int f, input logic [31:0] a,
                                           input logic [31:0] b, input logic [4:0] s);
        case (f)
            0: return b << s;
            1: return b >> s;
            2: return a + b;
            3: return a - b;
            4: return a & b;
            5: return a | b;
            6: return ~(a & b);
            7: return ~(a | b);
            8: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s instr=%h rs=%h rt=%h got=%h exp=%h", tag, instr, rs_val, rt_val, got, exp);
        end
    endtask

    // Apply one instruction and compare with the requirement-derived model.
    task automatic run(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
        logic [5:0]  op;
        logic [5:0]  fn;
        logic [4:0]  rt_i, rd_i, sh;
        logic [31:0] sx, e_res;
        logic [4:0]  e_dst;
        logic [5:0]  e_flags; // {reg_write, mem_read, mem_write, beq, bne, taken}
        string tag;
        @(negedge clk);
        instr = w; rs_val = a; rt_val = b;
        #1;
        op = w[31:26]; rt_i = w[20:16]; rd_i = w[15:11]; sh = w[10:6]; fn = w[5:0];
        sx = {{16{w[15]}}, w[15:0]};
        e_res = 0; e_dst = 0; e_flags = 0; tag = "R10";
        if (op == 6'd1 && fn <= 6'd8) begin
            e_res = ref_op(int'(fn), a, b, sh); e_dst = rd_i; e_flags = 6'b100000;
            tag = (fn <= 1) ? "R3" : (fn == 8) ? "R5" : (fn <= 3) ? "R6" : "R2";
        end else if (op >= 6'd2 && op <= 6'd8) begin
            e_res = ref_op(int'(op), a, sx, 5'd0); e_dst = rt_i; e_flags = 6'b100000;
            tag = (op == 8) ? "R5" : "R4";
        end else if (op == 6'd9) begin
            e_res = a + sx; e_dst = rt_i; e_flags = 6'b110000; tag = "R7";
        end else if (op == 6'd10) begin
            e_res = a + sx; e_flags = 6'b001000; tag = "R8";
        end else if (op == 6'd11) begin
            e_res = a - b; e_flags = {5'b00010, a == b}; tag = "R9";
        end else if (op == 6'd12) begin
            e_res = a - b; e_flags = {5'b00001, a != b}; tag = "R9";
        end
        chk(tag, alu_out, e_res);
        chk((e_flags[5] && e_dst == 0) ? "R11" : "R1", {27'd0, dest_reg}, {27'd0, e_dst});
        chk(tag, {26'd0, reg_write, mem_read, mem_write, branch_eq, branch_ne, branch_taken},
            {26'd0, e_flags});
    endtask

    initial begin
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
        vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h0000_000A;
        imms[0] = 16'h0000; imms[1] = 16'h0001; imms[2] = 16'h7FFF;
        imms[3] = 16'h8000; imms[4] = 16'hFFFB;
        shs[0] = 5'd0; shs[1] = 5'd1; shs[2] = 5'd5; shs[3] = 5'd31;
        instr = 0; rs_val = 0; rt_val = 0;

        // Idle state: all-zero word is a quiet no-op (R10).
        #1;
        chk("R10", {26'd0, reg_write, mem_read, mem_write, branch_eq, branch_ne, branch_taken}, 32'd0);
        chk("R10", alu_out, 32'd0);

        // Register 0 as destination: add-immediate 10 into index 0 (R11).
        run(32'h0800_000A, 32'd0, 32'd7);
        chk("R11", alu_out, 32'd10);
        // Sign-extended 0xFFFB acts as -5 (R4).
        run(32'h0820_FFFB, 32'd20, 32'd0);
        chk("R4", alu_out, 32'd15);
        // Wrap at the top of the range (R6).
        run({6'd1, 5'd1, 5'd2, 5'd3, 5'd0, 6'd2}, 32'hFFFF_FFFF, 32'd2);
        chk("R6", alu_out, 32'd1);

        for (int op = 0; op < 64; op++) begin
            if (op == 1) begin
                for (int fn = 0; fn < 64; fn++)
                    for (int si = 0; si < 4; si++)
                        for (int ia = 0; ia < 8; ia++)
                            for (int ib = 0; ib < 8; ib++)
                                run({6'd1, 5'(ia), 5'((ib * 5 + fn) % 32), 5'((fn + ia * 3) % 32),
                                     shs[si], 6'(fn)}, vals[ia], vals[ib]);
            end else begin
                for (int ii = 0; ii < 5; ii++)
                    for (int ia = 0; ia < 8; ia++)
                        for (int ib = 0; ib < 8; ib++)
                            run({6'(op), 5'(ia), 5'((ib * 7 + ii) % 32), imms[ii]}, vals[ia], vals[ib]);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 got=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule